// File: doc/BRIEF.md
# Nibble-Serial Analog Gamepad Responder

This block is the device end of a multiplexed gamepad port. It carries two 8-bit bidirectional stick axes (X, Y), one 8-bit unidirectional axis (Z) and eight buttons to a host over a 4-bit data field. Two handshake flags go with the data, and the whole port value is 7 bits wide.

The host fetches data with single-cycle read strobes. Each nibble is presented for four consecutive reads. A ready flag is high only on the first of those four reads. A half flag tells the host whether the first or the second half of a sequence of eight reads is being sent.

Host writes update a stored port state, but only in the bit positions the host drives. A select-line falling edge in that state restarts the transfer. Any other write moves on to the next sequence, but only once the host has read enough since the last restart. There are at most five sequences.

Top module: `apad_responder`

## Requirements
- R1: After reset the counter is 0, the latency count is 0 and the stored port state is 0x40. The idle port value therefore shows the first button nibble with bit 5 = 1 and bit 4 = 0.
- R2: `rd_data_o` bit 6 is always 1. Bits 3:0 are selected by the 6-bit counter divided by 4, as follows:
  - 0: inverted `btn_i[7:4]`
  - 1: inverted `btn_i[3:0]`
  - 2: X[7:4]
  - 3: Y[7:4]
  - 4: 0
  - 5: Z[7:4]
  - 6: X[3:0]
  - 7: Y[3:0]
  - 8: 0
  - 9: Z[3:0]
- R3: Buttons are active low on the port. A pressed (1) bit of `btn_i` reads as 0, at the same bit position within its nibble.
- R4: `rd_data_o` bit 4 equals counter bit 2. It is 0 for the first half of a sequence and 1 for the second half.
- R5: `rd_data_o` bit 5 is 1 when counter bits 1:0 are 0, and 0 otherwise.
- R6: A read without a write advances counter bits 2:0 modulo 8 and leaves bits 5:3 unchanged. The output reflects the new counter in the next cycle.
- R7: A write merges `wr_data_i` into the stored state only where `wr_mask_i` is 1. Unmasked bits keep their stored value.
- R8: If a merged write takes state bit 6 from 1 to 0, the counter and the latency count both clear to 0.
- R9: Any other write sets the counter to (counter & ~7) + 8, capped at 32. This happens only when the latency count is above 2. Otherwise the counter is unchanged.
- R10: Each read adds 1 to the latency count, which saturates at 255. When a read and a write come in the same cycle, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wr_data_i | input | 7 | Host write data |
| wr_mask_i | input | 7 | Direction mask; 1 = bit driven by host |
| axis_x_i | input | 8 | X axis value |
| axis_y_i | input | 8 | Y axis value |
| axis_z_i | input | 8 | Z axis value |
| btn_i | input | 8 | Button states, 1 = pressed |
| rd_data_o | output | 7 | Port value for the current access |

## Verification
The port value is a direct function of the counter. A wrong counter shows as a wrong nibble or a wrong flag in the cycle after the strobe that caused it.

The latency count is hidden. A fault in it shows only at the next non-restart write, when the sequence either advances or stays put. Likewise, a wrong stored state shows only when a later write fails to restart, or restarts when it should not.

For that reason the reference model checks every cycle, and each write is followed by reads that expose the counter.

// File: rtl/apad_pkg.sv
package apad_pkg;
  localparam int PORT_W   = 7;
  localparam int SEL_BIT  = 6;
  localparam int RDY_BIT  = 5;
  localparam int HALF_BIT = 4;
  localparam logic [PORT_W-1:0] STATE_RST = 7'h40;
  typedef logic [PORT_W-1:0] port_t;
endpackage

// File: rtl/apad_port_state.sv
module apad_port_state
  import apad_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  port_t wr_data_i,
  input  port_t wr_mask_i,
  output logic  restart_o
);
  port_t state_q, merged;

  assign merged    = (state_q & ~wr_mask_i) | (wr_data_i & wr_mask_i);
  assign restart_o = wr_i & state_q[SEL_BIT] & ~merged[SEL_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   state_q <= STATE_RST;
    else if (wr_i) state_q <= merged;
  end

  // R7: bits outside the mask survive a write
  p_keep_unmasked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((state_q & ~$past(wr_mask_i)) == ($past(state_q) & ~$past(wr_mask_i))));

  // R7: no write, no state change
  p_hold_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(state_q));
endmodule

// File: rtl/apad_seq_track.sv
module apad_seq_track #(
  parameter int CYC_W   = 3,
  parameter int SEQ_MAX = 5,
  parameter int LAT_W   = 8,
  parameter int LAT_MIN = 2,
  localparam int SEQ_W  = $clog2(SEQ_MAX),
  localparam int CNT_W  = CYC_W + SEQ_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(SEQ_MAX - 1);

  logic [CYC_W-1:0] cyc_q;
  logic [SEQ_W-1:0] seq_q, seq_nxt;
  logic [LAT_W-1:0] lat_q;
  logic             lat_ok;

  assign lat_ok  = lat_q > LAT_W'(LAT_MIN);
  assign seq_nxt = (seq_q >= SEQ_LAST) ? SEQ_LAST : seq_q + SEQ_W'(1);
  assign cnt_o   = {seq_q, cyc_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      seq_q <= '0;
      lat_q <= '0;
    end else if (wr_i) begin
      if (restart_i) begin
        cyc_q <= '0;
        seq_q <= '0;
        lat_q <= '0;
      end else if (lat_ok) begin
        cyc_q <= '0;
        seq_q <= seq_nxt;
      end
    end else if (rd_i) begin
      cyc_q <= cyc_q + CYC_W'(1);
      if (lat_q != '1) lat_q <= lat_q + LAT_W'(1);
    end
  end

  p_restart_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && restart_i) |=> (cnt_o == '0 && lat_q == '0));

  p_read_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i) |=> (cyc_q == $past(cyc_q) + CYC_W'(1) && seq_q == $past(seq_q)));

  p_seq_cap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_q <= SEQ_LAST);

  p_lat_sat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && lat_q == '1) |=> lat_q == '1);

  p_wr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !restart_i && !lat_ok) |=> $stable(cnt_o));
endmodule

// File: rtl/apad_nibble_mux.sv
module apad_nibble_mux
  import apad_pkg::*;
#(
  parameter int AXIS_W = 8,
  parameter int CNT_W  = 6,
  localparam int NIB_W = 4,
  localparam int GRP_W = CNT_W - 2
) (
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [AXIS_W-1:0] axis_x_i,
  input  logic [AXIS_W-1:0] axis_y_i,
  input  logic [AXIS_W-1:0] axis_z_i,
  input  logic [7:0]        btn_i,
  output port_t             port_o
);
  logic [GRP_W-1:0] grp;
  logic [NIB_W-1:0] nib;

  assign grp = cnt_i[CNT_W-1:2];

  always_comb begin
    case (grp)
      GRP_W'(0): nib = ~btn_i[7:4];
      GRP_W'(1): nib = ~btn_i[3:0];
      GRP_W'(2): nib = axis_x_i[AXIS_W-1 -: NIB_W];
      GRP_W'(3): nib = axis_y_i[AXIS_W-1 -: NIB_W];
      GRP_W'(5): nib = axis_z_i[AXIS_W-1 -: NIB_W];
      GRP_W'(6): nib = axis_x_i[NIB_W-1:0];
      GRP_W'(7): nib = axis_y_i[NIB_W-1:0];
      GRP_W'(9): nib = axis_z_i[NIB_W-1:0];
      default:   nib = '0;
    endcase
  end

  assign port_o = {1'b1, (cnt_i[1:0] == 2'b00), cnt_i[2], nib};
endmodule

// File: rtl/apad_responder.sv
module apad_responder
  import apad_pkg::*;
#(
  parameter int AXIS_W  = 8,
  parameter int SEQ_MAX = 5,
  parameter int LAT_W   = 8,
  parameter int LAT_MIN = 2,
  localparam int CYC_W  = 3,
  localparam int CNT_W  = CYC_W + $clog2(SEQ_MAX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [6:0]        wr_data_i,
  input  logic [6:0]        wr_mask_i,
  input  logic [AXIS_W-1:0] axis_x_i,
  input  logic [AXIS_W-1:0] axis_y_i,
  input  logic [AXIS_W-1:0] axis_z_i,
  input  logic [7:0]        btn_i,
  output logic [6:0]        rd_data_o
);
  logic             restart;
  logic [CNT_W-1:0] cnt;

  apad_port_state u_state (
    .clk_i, .rst_ni, .wr_i,
    .wr_data_i, .wr_mask_i,
    .restart_o (restart)
  );

  apad_seq_track #(
    .CYC_W(CYC_W), .SEQ_MAX(SEQ_MAX), .LAT_W(LAT_W), .LAT_MIN(LAT_MIN)
  ) u_seq (
    .clk_i, .rst_ni, .rd_i, .wr_i,
    .restart_i (restart),
    .cnt_o     (cnt)
  );

  apad_nibble_mux #(.AXIS_W(AXIS_W), .CNT_W(CNT_W)) u_mux (
    .cnt_i (cnt),
    .axis_x_i, .axis_y_i, .axis_z_i, .btn_i,
    .port_o (rd_data_o)
  );

  // R5: ready flag lasts one read only
  p_ready_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && rd_data_o[RDY_BIT]) |=> !rd_data_o[RDY_BIT]);

  // R4: half flag toggles only on a read from cycle 3 or 7, or on a write
  p_half_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !(rd_i && cnt[1:0] == 2'b11)) |=> $stable(rd_data_o[HALF_BIT]));
endmodule

// File: tb/apad_responder_tb_top.sv
`timescale 1ns/1ps
module apad_responder_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rd = 1'b0, wr = 1'b0;
  logic [6:0] wdat = '0, wmsk = '0;
  logic [7:0] ax = 8'h80, ay = 8'h80, az = 8'h80, btn = '0;
  logic [6:0] dout;

  int errs = 0, checks = 0;
  int m_state, m_cnt, m_lat;
  bit done = 0;

  always #2.5 clk = ~clk;

  apad_responder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr),
    .wr_data_i(wdat), .wr_mask_i(wmsk),
    .axis_x_i(ax), .axis_y_i(ay), .axis_z_i(az), .btn_i(btn),
    .rd_data_o(dout)
  );

  function automatic int exp_port();
    int n;
    case (m_cnt / 4)
      0: n = (~btn >> 4) & 15;
      1: n = ~btn & 15;
      2: n = ax / 16;
      3: n = ay / 16;
      5: n = az / 16;
      6: n = ax % 16;
      7: n = ay % 16;
      9: n = az % 16;
      default: n = 0;
    endcase
    return 64 + (((m_cnt % 4) == 0) ? 32 : 0) + (((m_cnt / 4) % 2) * 16) + n;
  endfunction

  task automatic chk(string tag);
    int e;
    e = exp_port();
    checks++;
    if (int'(dout) != e) begin
      errs++;
      $display("FAIL %s: port=%02h expected %02h (cnt=%0d)", tag, dout, e, m_cnt);
    end
  endtask

  task automatic op(bit r, bit w, int d, int m, string tag);
    int mg;
    @(negedge clk);
    chk(tag);
    rd = r; wr = w; wdat = 7'(d); wmsk = 7'(m);
    @(posedge clk); #1;
    rd = 0; wr = 0;
    if (w) begin
      mg = ((m_state & ~m) | (d & m)) & 127;
      if (((mg & 64) == 0) && ((m_state & 64) != 0)) begin
        m_cnt = 0; m_lat = 0;
      end else if (m_lat > 2) begin
        m_cnt = (m_cnt & ~7) + 8;
        if (m_cnt > 32) m_cnt = 32;
      end
      m_state = mg;
    end else if (r) begin
      m_cnt = (m_cnt & ~7) | ((m_cnt + 1) & 7);
      if (m_lat < 255) m_lat++;
    end
  endtask

  task automatic reads(int n, string tag);
    for (int i = 0; i < n; i++) op(1, 0, 0, 0, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    m_state = 64; m_cnt = 0; m_lat = 0;
    #12 rst_n = 1'b1;
    op(0, 0, 0, 0, "R1 reset idle");
    btn = 8'b1010_0110; ax = 8'h3C; ay = 8'hD5; az = 8'h9E;
    reads(8, "R2 R3 R4 R5 R6 seq0");
    // mask keeps bit 6 high: no restart, latency 8 -> advance (R7 R9)
    op(0, 1, 0, 7'h3F, "R7 R9 masked write");
    reads(10, "R2 R4 R6 seq1 wrap");
    btn = 8'b0101_1001;
    for (int i = 0; i < 5; i++) op(0, 1, 7'h40, 7'h40, "R9 advance to cap");
    reads(9, "R2 R9 capped seq");
    op(0, 1, 0, 7'h40, "R8 restart");
    reads(3, "R8 R3 after restart");
    op(0, 1, 7'h40, 7'h40, "R9 latency 3 advance");
    op(0, 1, 0, 7'h40, "R8 restart");
    op(0, 1, 7'h40, 7'h40, "R9 latency 0 hold");
    reads(2, "R6 two reads");
    op(0, 1, 7'h40, 7'h40, "R9 latency 2 hold");
    reads(1, "R6 third read");
    op(0, 1, 0, 7'h00, "R7 empty mask no restart");
    reads(2, "R6 R7 after empty mask");
    op(0, 1, 0, 7'h40, "R8 restart");
    op(0, 1, 7'h40, 7'h40, "R7 raise select");
    op(0, 1, 7'h7F, 7'h3F, "R7 other bits high");
    op(0, 1, 0, 7'h40, "R8 restart from mixed state");
    ax = 8'hF1; ay = 8'h0E; az = 8'h77; btn = 8'hFF;
    reads(256, "R10 latency run");
    op(0, 1, 7'h40, 7'h40, "R10 saturated latency advance");
    reads(3, "R10 after saturation");
    op(1, 1, 7'h40, 7'h40, "R10 write priority");
    reads(8, "R10 R2 after priority");
    op(1, 1, 0, 7'h40, "R10 R8 restart with read");
    reads(4, "R2 R5 final");
    op(0, 0, 0, 0, "R1 final idle");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule